// File: doc/BRIEF.md
# External Bus Cycle Sequencer

This block turns single read and write requests from a processor core into timed strobes on an external memory bus. It accepts a request only while it is not busy. It then drives an address strobe, a read or write strobe and the enable of the write-data driver. It pulses a one-clock ready back to the requester when each transfer finishes. A plain access takes two states. A programmed count of zero to three extra states can stretch it. When the pin-wait option is on, an external hold input can stretch it further after the programmed states have run out.

Reads may use a burst mode meant for slow ROM. The first transfer is a full access that can be stretched like any other. The transfers after it take one state each and cannot be stretched. The burst length is four or eight, and the low address bits wrap inside that length. When a write directly follows a read and the turnaround option is enabled, one dead state is placed at the front of the write. During that state nothing is driven, so a slow device has time to release the data lines. A narrow addressing mode clears the address bits above bit 15. Turnaround insertion works the same way in both addressing modes.

Top module: `xbus_seq`

## Requirements
- R1: A synchronous reset, including one that arrives mid-access, clears every strobe, `ready_o` and `busy_o` to 0 in the state after it. It also erases the memory of a previous read, so a write right after reset gets no dead state.
- R2: A request seen while `busy_o` is 0 is accepted at that clock edge. With no waits, the access occupies the next two states, and `ready_o` is high in the second of them.
- R3: `cfg_wait_states` (0 to 3) adds that many states between the first state and the ready state, and `ext_wait` has no effect while `cfg_pin_wait` is 0.
- R4: With `cfg_pin_wait` = 1, `ext_wait` is first sampled at the end of the last programmed wait state, or at the end of the first state when the count is 0. Every consecutive high sample adds one state, and samples taken earlier are ignored.
- R5: A read with `req_burst` = 1 completes a full first transfer, then performs further one-state transfers up to a total of 4 (`cfg_burst8` = 0) or 8 (`cfg_burst8` = 1), with `ready_o` high in each. `req_burst` is ignored on writes.
- R6: `ext_wait` is ignored during the one-state burst transfers.
- R7: During a burst, transfer k (counting from 0) drives an address whose low 2 bits (length 4) or low 3 bits (length 8) equal the start value plus k modulo the length. All other bits stay those of the start address.
- R8: If the previous external access was a read and `cfg_idle_en` = 1, a write gets exactly one extra leading state. In that state `as_o`, `wr_o` and `dout_oe_o` are 0.
- R9: No leading state is added for read after read, write after write, a write with `cfg_idle_en` = 0, or a write preceded by an `int_cycle` pulse after the read.
- R10: `dout_oe_o` is 1 only in write accesses, from the first state that is not the dead state through the ready state.
- R11: `ready_o` is high for exactly one clock per transfer and is low in the idle state that follows an access.
- R12: `as_o` is high in every state of an access except the dead state. `rd_o` is high with it for reads, and `wr_o` is high with it for writes.
- R13: With `cfg_wide` = 0, `bus_addr_o` bits 23..16 read 0. With `cfg_wide` = 1, the full address is driven.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_burst | input | 1 | Burst read request |
| req_addr | input | 24 | Start address |
| int_cycle | input | 1 | Internal-only cycle ran; forgets the last read |
| cfg_wait_states | input | 2 | Programmed extra states |
| cfg_pin_wait | input | 1 | Enable external hold sampling |
| cfg_idle_en | input | 1 | Enable read-to-write dead state |
| cfg_burst8 | input | 1 | Burst length 8 when 1, else 4 |
| cfg_wide | input | 1 | Full-width address when 1 |
| ext_wait | input | 1 | External hold request, active high |
| busy_o | output | 1 | Access in progress |
| bus_addr_o | output | 24 | Bus address |
| as_o | output | 1 | Address strobe |
| rd_o | output | 1 | Read strobe |
| wr_o | output | 1 | Write strobe |
| dout_oe_o | output | 1 | Write data driver enable |
| ready_o | output | 1 | Transfer complete, one clock |

## Verification
The strobes and ready are registered from the next-state value, so the state entered at an edge shows at the ports in the cycle after it. Counting from the accept edge, ready is due in cycle 2 + dead + programmed + extra pin states. The extra pin count is the run of high samples that starts at cycle 1 + dead + programmed. Burst readies follow in the next consecutive cycles, and the idle state comes one cycle after the last ready. The bench samples at the falling edge of every cycle from 1 up to that count and compares all strobes against this model. It changes `ext_wait` only at falling edges, so each sample is seen at exactly one rising edge.

// File: rtl/xbus_pkg.sv
package xbus_pkg;

  typedef enum logic [2:0] {
    S_IDLE = 3'd0,
    S_TI   = 3'd1,
    S_T1   = 3'd2,
    S_TW   = 3'd3,
    S_TP   = 3'd4,
    S_T2   = 3'd5,
    S_TB   = 3'd6
  } xbus_st_e;

  // states in which the address strobe is driven
  function automatic logic st_active(input xbus_st_e s);
    return (s == S_T1) || (s == S_TW) || (s == S_TP) || (s == S_T2) || (s == S_TB);
  endfunction

  // states that finish one transfer
  function automatic logic st_done(input xbus_st_e s);
    return (s == S_T2) || (s == S_TB);
  endfunction

endpackage

// File: rtl/xbus_wait_ctr.sv
module xbus_wait_ctr #(
  parameter int WCW = 2
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           load,
  input  logic [WCW-1:0] load_val,
  input  logic           dec,
  output logic           last_o
);
  localparam logic [WCW-1:0] ONE = WCW'(1);

  logic [WCW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)       cnt_q <= '0;
    else if (load) cnt_q <= load_val;
    else if (dec)  cnt_q <= cnt_q - ONE;
  end

  assign last_o = (cnt_q == ONE);

  AST_WAIT_DEC_NONZERO: assert property (@(posedge clk) disable iff (rst)
    dec |-> (cnt_q != '0)); // R3

endmodule

// File: rtl/xbus_burst_ctr.sv
module xbus_burst_ctr #(
  parameter int AW = 24,
  parameter int IW = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [AW-1:0] base_i,
  input  logic          long_i,
  input  logic          step,
  output logic [AW-1:0] addr_o,
  output logic          last_o
);
  localparam logic [IW-1:0] LONG_MASK  = '1;
  localparam logic [IW-1:0] SHORT_MASK = LONG_MASK >> 1;

  logic [AW-1:0] base_q;
  logic [IW-1:0] idx_q;
  logic          long_q;
  logic [IW-1:0] mask;
  logic [IW-1:0] sum;

  always_ff @(posedge clk) begin
    if (rst) begin
      base_q <= '0;
      idx_q  <= '0;
      long_q <= 1'b0;
    end else if (load) begin
      base_q <= base_i;
      idx_q  <= '0;
      long_q <= long_i;
    end else if (step) begin
      idx_q  <= idx_q + IW'(1);
    end
  end

  always_comb begin
    mask   = long_q ? LONG_MASK : SHORT_MASK;
    sum    = base_q[IW-1:0] + idx_q;
    addr_o = {base_q[AW-1:IW], (base_q[IW-1:0] & ~mask) | (sum & mask)};
    last_o = (idx_q == mask);
  end

  AST_BURST_UPPER_HELD: assert property (@(posedge clk) disable iff (rst)
    (step && !load) |=> (addr_o[AW-1:IW] == $past(addr_o[AW-1:IW]))); // R7

endmodule

// File: rtl/xbus_turn.sv
module xbus_turn (
  input  logic clk,
  input  logic rst,
  input  logic rd_done,
  input  logic wr_done,
  input  logic int_cyc,
  output logic prev_rd_o
);
  always_ff @(posedge clk) begin
    if (rst)          prev_rd_o <= 1'b0;
    else if (int_cyc) prev_rd_o <= 1'b0;
    else if (rd_done) prev_rd_o <= 1'b1;
    else if (wr_done) prev_rd_o <= 1'b0;
  end

  AST_INT_FORGETS_READ: assert property (@(posedge clk) disable iff (rst)
    int_cyc |=> !prev_rd_o); // R9
  AST_WRITE_FORGETS_READ: assert property (@(posedge clk) disable iff (rst)
    (wr_done && !rd_done && !int_cyc) |=> !prev_rd_o); // R9

endmodule

// File: rtl/xbus_seq.sv
module xbus_seq #(
  parameter int AW       = 24,
  parameter int WCW      = 2,
  parameter int BIW      = 3,
  parameter int NARROW_W = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req_valid,
  input  logic          req_write,
  input  logic          req_burst,
  input  logic [AW-1:0] req_addr,
  input  logic          int_cycle,
  input  logic [WCW-1:0] cfg_wait_states,
  input  logic          cfg_pin_wait,
  input  logic          cfg_idle_en,
  input  logic          cfg_burst8,
  input  logic          cfg_wide,
  input  logic          ext_wait,
  output logic          busy_o,
  output logic [AW-1:0] bus_addr_o,
  output logic          as_o,
  output logic          rd_o,
  output logic          wr_o,
  output logic          dout_oe_o,
  output logic          ready_o
);
  import xbus_pkg::*;

  localparam logic [AW-1:0] NARROW_MASK = {{(AW-NARROW_W){1'b0}}, {NARROW_W{1'b1}}};

  xbus_st_e       st_q, st_n, decide;
  logic           accept;
  logic           wr_q, wr_n, bst_q, pin_q, wide_q;
  logic [WCW-1:0] wcnt_q;
  logic           w_last, b_last, prev_rd;
  logic [AW-1:0]  burst_addr;
  logic           done;

  assign accept = (st_q == S_IDLE) && req_valid;
  assign done   = st_done(st_q);

  // captured request attributes
  always_ff @(posedge clk) begin
    if (rst) begin
      wr_q   <= 1'b0;
      bst_q  <= 1'b0;
      pin_q  <= 1'b0;
      wide_q <= 1'b0;
      wcnt_q <= '0;
    end else if (accept) begin
      wr_q   <= req_write;
      bst_q  <= req_burst && !req_write;
      pin_q  <= cfg_pin_wait;
      wide_q <= cfg_wide;
      wcnt_q <= cfg_wait_states;
    end
  end

  xbus_wait_ctr #(.WCW(WCW)) u_wait (
    .clk      (clk),
    .rst      (rst),
    .load     (st_q == S_T1),
    .load_val (wcnt_q),
    .dec      (st_q == S_TW),
    .last_o   (w_last)
  );

  xbus_burst_ctr #(.AW(AW), .IW(BIW)) u_burst (
    .clk    (clk),
    .rst    (rst),
    .load   (accept),
    .base_i (req_addr),
    .long_i (cfg_burst8),
    .step   (done),
    .addr_o (burst_addr),
    .last_o (b_last)
  );

  xbus_turn u_turn (
    .clk       (clk),
    .rst       (rst),
    .rd_done   (done && !wr_q),
    .wr_done   (done && wr_q),
    .int_cyc   (int_cycle),
    .prev_rd_o (prev_rd)
  );

  // end of programmed waits: hold on the pin or finish
  assign decide = (pin_q && ext_wait) ? S_TP : S_T2;

  always_comb begin
    st_n = st_q;
    unique case (st_q)
      S_IDLE: if (accept) st_n = (req_write && prev_rd && cfg_idle_en) ? S_TI : S_T1;
      S_TI:   st_n = S_T1;
      S_T1:   st_n = (wcnt_q == '0) ? decide : S_TW;
      S_TW:   st_n = w_last ? decide : S_TW;
      S_TP:   st_n = ext_wait ? S_TP : S_T2;
      S_T2:   st_n = (bst_q && !b_last) ? S_TB : S_IDLE;
      S_TB:   st_n = b_last ? S_IDLE : S_TB;
      default: st_n = S_IDLE;
    endcase
  end

  assign wr_n = accept ? req_write : wr_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q      <= S_IDLE;
      busy_o    <= 1'b0;
      as_o      <= 1'b0;
      rd_o      <= 1'b0;
      wr_o      <= 1'b0;
      dout_oe_o <= 1'b0;
      ready_o   <= 1'b0;
    end else begin
      st_q      <= st_n;
      busy_o    <= (st_n != S_IDLE);
      as_o      <= st_active(st_n);
      rd_o      <= st_active(st_n) && !wr_n;
      wr_o      <= st_active(st_n) && wr_n;
      dout_oe_o <= st_active(st_n) && wr_n;
      ready_o   <= st_done(st_n);
    end
  end

  assign bus_addr_o = wide_q ? burst_addr : (burst_addr & NARROW_MASK);

  AST_DEAD_STATE_QUIET: assert property (@(posedge clk) disable iff (rst)
    (st_q == S_TI) |-> (!dout_oe_o && !as_o && !wr_o)); // R8
  AST_DEAD_THEN_WRITE: assert property (@(posedge clk) disable iff (rst)
    (st_q == S_TI) |=> ((st_q == S_T1) && wr_o)); // R8
  AST_BURST_NO_STALL: assert property (@(posedge clk) disable iff (rst)
    (st_q == S_TB) |=> ((st_q == S_TB) || (st_q == S_IDLE))); // R6
  AST_OE_ONLY_WRITE: assert property (@(posedge clk) disable iff (rst)
    dout_oe_o |-> (wr_o && !rd_o)); // R10
  AST_READY_WITH_STROBE: assert property (@(posedge clk) disable iff (rst)
    ready_o |-> as_o); // R11
  AST_SINGLE_READY: assert property (@(posedge clk) disable iff (rst)
    (ready_o && !bst_q) |=> !ready_o); // R11
  AST_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (rst)
    accept |=> busy_o); // R2

endmodule

// File: tb/xbus_seq_test.sv
module xbus_seq_test;
  localparam int AW = 24;
  localparam int NROWS = 14;
  // row: [11]wr [10]burst [9:8]waits [7]pin [6:4]hold cycles [3]idle_en [2]int before [1]len8 [0]wide
  localparam logic [11:0] ROWS [NROWS] = '{
    12'b0_0_00_0_000_1_0_0_1, // R2 plain read
    12'b1_0_00_0_000_1_0_0_1, // R8 write after read
    12'b1_0_00_0_000_1_0_0_1, // R9 write after write
    12'b0_0_11_0_011_1_0_0_1, // R3 three waits, hold ignored
    12'b1_0_00_0_000_0_0_0_1, // R9 idle disabled
    12'b0_0_01_1_100_1_0_0_1, // R4 pin wait after one wait
    12'b1_0_00_0_000_1_1_0_1, // R9 internal cycle between
    12'b0_1_00_0_000_1_0_0_1, // R5 burst 4
    12'b0_1_10_1_001_1_0_1_1, // R4 R5 burst 8, early hold ignored
    12'b0_0_00_1_010_1_0_0_1, // R4 pin hold 2, read after read
    12'b1_0_10_1_101_1_0_0_0, // R8 R13 idle + waits + pin, narrow
    12'b1_1_00_0_000_1_0_0_1, // R5 burst flag on write ignored
    12'b0_1_00_0_000_1_0_1_0, // R7 R13 narrow burst 8
    12'b1_0_00_0_000_1_0_0_1  // R8 write after burst read
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req_valid = 0, req_write = 0, req_burst = 0, int_cycle = 0;
  logic [AW-1:0] req_addr = '0;
  logic [1:0] cfg_wait_states = 0;
  logic cfg_pin_wait = 0, cfg_idle_en = 0, cfg_burst8 = 0, cfg_wide = 1, ext_wait = 0;
  logic busy_o, as_o, rd_o, wr_o, dout_oe_o, ready_o;
  logic [AW-1:0] bus_addr_o;

  int n_chk = 0, n_err = 0;
  logic prev_rd = 0;
  logic finished = 0;

  always #10 clk = ~clk;

  xbus_seq uut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
    .req_burst(req_burst), .req_addr(req_addr), .int_cycle(int_cycle),
    .cfg_wait_states(cfg_wait_states), .cfg_pin_wait(cfg_pin_wait),
    .cfg_idle_en(cfg_idle_en), .cfg_burst8(cfg_burst8), .cfg_wide(cfg_wide),
    .ext_wait(ext_wait), .busy_o(busy_o), .bus_addr_o(bus_addr_o), .as_o(as_o),
    .rd_o(rd_o), .wr_o(wr_o), .dout_oe_o(dout_oe_o), .ready_o(ready_o)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [AW-1:0] exp_addr(input logic [AW-1:0] base, input int k,
                                             input logic bst, input logic len8, input logic wide);
    logic [AW-1:0] mask, a;
    mask = bst ? (len8 ? 24'h7 : 24'h3) : 24'h0;
    a = (base & ~mask) | ((base + AW'(k)) & mask);
    if (!wide) a[23:16] = 8'h00;
    return a;
  endfunction

  // runs from a falling edge in the idle state; returns at the falling edge of the idle state after
  task automatic run_access(input logic [11:0] r, input logic [AW-1:0] base);
    logic wr, bst, pin, ien, intb, l8, wd, dead;
    int w, m, d, extra, lat, blen;
    wr = r[11]; bst = r[10] && !r[11]; w = int'(r[9:8]); pin = r[7]; m = int'(r[6:4]);
    ien = r[3]; intb = r[2]; l8 = r[1]; wd = r[0];
    if (intb) begin
      int_cycle = 1; @(negedge clk); int_cycle = 0; prev_rd = 0;
    end
    dead = wr && prev_rd && ien;
    d = 1 + int'(dead) + w;
    extra = (pin && m >= d) ? (m - d + 1) : 0;
    lat = 2 + int'(dead) + w + extra;
    blen = bst ? (l8 ? 8 : 4) : 1;
    req_valid = 1; req_write = wr; req_burst = r[10]; req_addr = base;
    cfg_wait_states = r[9:8]; cfg_pin_wait = pin; cfg_idle_en = ien;
    cfg_burst8 = l8; cfg_wide = wd; ext_wait = 0;
    @(posedge clk);
    for (int n = 1; n <= lat; n++) begin
      @(negedge clk);
      req_valid = 0;
      ext_wait = (n <= m);
      check("R2/R3/R4/R11 ready", 32'(ready_o), 32'(n == lat));
      check("R8/R12 as", 32'(as_o), 32'(n > int'(dead)));
      check("R12 rd", 32'(rd_o), 32'(!wr && n > int'(dead)));
      check("R12 wr", 32'(wr_o), 32'(wr && n > int'(dead)));
      check("R10 oe", 32'(dout_oe_o), 32'(wr && n > int'(dead)));
      check("R2 busy", 32'(busy_o), 32'd1);
      if (n == lat) check("R7/R13 addr", 32'(bus_addr_o), 32'(exp_addr(base, 0, bst, l8, wd)));
    end
    for (int k = 1; k < blen; k++) begin
      @(negedge clk);
      ext_wait = 1; // R6 hold must not stretch burst transfers
      check("R5/R6 burst ready", 32'(ready_o), 32'd1);
      check("R7 burst addr", 32'(bus_addr_o), 32'(exp_addr(base, k, bst, l8, wd)));
      check("R10 oe in read burst", 32'(dout_oe_o), 32'd0);
    end
    @(negedge clk);
    ext_wait = 0;
    check("R11 ready after access", 32'(ready_o), 32'd0);
    check("R12 as after access", 32'(as_o), 32'd0);
    check("R2 busy after access", 32'(busy_o), 32'd0);
    prev_rd = !wr;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_err++;
      $display("FAIL R1 watchdog actual=timeout expected=completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1 reset as", 32'(as_o), 32'd0);
    check("R1 reset ready", 32'(ready_o), 32'd0);
    check("R1 reset oe", 32'(dout_oe_o), 32'd0);
    check("R1 reset busy", 32'(busy_o), 32'd0);
    rst = 0;
    @(negedge clk);

    for (int i = 0; i < NROWS; i++)
      run_access(ROWS[i], 24'hA50000 + AW'(i * 5));

    // R1: reset in the middle of a waited read, then a write sees no dead state
    req_valid = 1; req_write = 0; req_burst = 0; req_addr = 24'h123456;
    cfg_wait_states = 2'd3; cfg_pin_wait = 0; cfg_idle_en = 1; cfg_wide = 1;
    @(posedge clk);
    @(negedge clk); req_valid = 0;
    @(negedge clk);
    rst = 1;
    @(negedge clk);
    check("R1 mid reset as", 32'(as_o), 32'd0);
    check("R1 mid reset rd", 32'(rd_o), 32'd0);
    check("R1 mid reset busy", 32'(busy_o), 32'd0);
    rst = 0;
    prev_rd = 0;
    @(negedge clk);
    run_access(12'b1_0_00_0_000_1_0_0_1, 24'h00BEEF); // R1 no dead state after reset

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
    $finish;
  end
endmodule